// File: doc/BRIEF.md
# I2C Bus-Hang Recovery Sequencer

This block frees an I2C bus after a controller lost its place in the middle of a transfer. In that situation a target can be left holding SDA low while it waits for clocks that never arrive. The sequencer runs on the controller side and drives both bus lines open-drain. It starts on a request, or by itself when it sees SDA low with SCL high on an idle bus for long enough.

Once started, it releases SDA and issues single SCL pulses. It samples SDA after each pulse and stops pulsing as soon as SDA reads high. It then forms a STOP condition and checks SDA once more. A target whose next bit happens to be a 1 can release SDA only for a moment. To handle that case, a whole attempt (pulses followed by STOP) is repeated up to a chosen number of times.

If SDA is still low when all attempts are used up, the block does one of two things. It can drive a timed active-low reset strobe to a switch that cuts the target's supply, then wait for the supply to return. If escalation is not enabled, it reports failure instead.

Top module: `i2c_bus_recover`

## Requirements
- R1: During and right after reset, both pad enables are 0 (lines released), slave_rst_n_o is 1, and busy_o, done_o and fail_o are 0.
- R2: A pad enable of 1 pulls its line low. A recovery pulse pulls SCL low for HALF_CYC cycles and then releases it, with SDA released throughout. SDA is sampled once before the first pulse and once after every pulse. Pulsing continues while the sample is 0, up to MAX_PULSES (default 9) pulses in one attempt.
- R3: When a sample reads 1, the block forms a STOP condition. It pulls SCL low, then pulls SDA low, then releases SCL, and releases SDA only after SCL has been high for a half period. A successful STOP (SDA high afterwards) ends the run with done_o=1.
- R4: An attempt fails if SDA stays low after MAX_PULSES pulses, or if SDA is low after the STOP. A failed attempt is followed by a new one, as long as fewer than retries_i+1 attempts have been made. retries_i is latched when the run starts.
- R5: When all attempts fail and esc_en_i was 1 at the start, slave_rst_n_o goes low for at least RST_LOW_CYC cycles. After it rises, the block waits at least PWR_WAIT_CYC cycles and then reports done_o=1.
- R6: When all attempts fail and esc_en_i was 0 at the start, the run ends with fail_o=1, done_o=0, and no reset strobe.
- R7: busy_o is 1 for the whole run. done_o and fail_o are never 1 together, are 0 while busy, and hold their value until the next run starts.
- R8: With the block idle and fail_o=0, if SDA is seen low while SCL is high for STUCK_CYC consecutive cycles, a run starts without start_i.
- R9: While fail_o=1, a stuck bus does not start a run. start_i still does.
- R10: After releasing SCL, the block waits for SCL to read high before timing the high half period. A target stretching the clock therefore never shortens the high phase below HALF_CYC cycles.
- R11: SDA is pulled low only while SCL is also being pulled low, and SDA is released only while SCL reads high.
- R12: start_i pulsed while a run is in progress has no effect. The number of SCL pulses and the outcome match a run with a single request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run recovery |
| retries_i | input | RETRY_W | Extra attempts allowed after the first |
| esc_en_i | input | 1 | Allow supply-cut reset when attempts run out |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| slave_rst_n_o | output | 1 | Active-low strobe to the target supply switch |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | Last run ended with the bus freed |
| fail_o | output | 1 | Last run gave up without escalation |

## Verification
The pulse counter, the attempt counter and the phase timer can each go wrong inside the block. Whichever one does, the number of SCL falling edges per run changes, and that count is checked against a model of a target that shifts one bit per falling edge. An error in the STOP ordering shows up on the lines as a missing STOP event, or as a change on SDA while SCL is low. The pad checks catch it on the clock where it happens. A wrong outcome decision, or a reset strobe that is too short, appears at done_o, fail_o or slave_rst_n_o by the end of that same run.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;
   typedef enum logic [3:0] {
      RS_IDLE,
      RS_PROBE,
      RS_PLO,
      RS_PHI,
      RS_SLO,
      RS_SSDA,
      RS_SHI,
      RS_SREL,
      RS_RLOW,
      RS_RWAIT
   } rcv_state_e;
endpackage

// File: rtl/i2c_rcv_sync.sv
module i2c_rcv_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] d_i,
   output logic [LINES-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rcv_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '1;
         else        sh_q <= {sh_q[STAGES-2:0], d_i[g]};
      end
      assign q_o[g] = sh_q[STAGES-1];
   end
endmodule

// File: rtl/i2c_rcv_timer.sv
module i2c_rcv_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   input  logic         en_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load_i)              cnt_q <= val_i;
      else if (en_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_rcv_stuck.sv
module i2c_rcv_stuck #(
   parameter int CYC    = 2000,
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic sda_i,
   input  logic scl_i,
   output logic stuck_o
);
   localparam int CW = $clog2(CYC + 1);

   if (ENABLE) begin : g_det
      logic [CW-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          run_q <= '0;
         else if (!arm_i || sda_i || !scl_i)  run_q <= '0;
         else if (run_q != CW'(CYC))          run_q <= run_q + 1'b1;
      end
      assign stuck_o = arm_i && (run_q == CW'(CYC));
   end else begin : g_off
      assign stuck_o = 1'b0;
   end
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
   import i2c_rcv_pkg::*;
#(
   parameter int HALF_CYC     = 1000,
   parameter int RST_LOW_CYC  = 3000,
   parameter int PWR_WAIT_CYC = 1000,
   parameter int STUCK_CYC    = 2000,
   parameter int MAX_PULSES   = 9,
   parameter int RETRY_W      = 2,
   parameter int SYNC_STAGES  = 2,
   parameter bit AUTO_DETECT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [RETRY_W-1:0] retries_i,
   input  logic               esc_en_i,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               scl_oe_o,
   output logic               sda_oe_o,
   output logic               slave_rst_n_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               fail_o
);
   localparam int TMAX = (HALF_CYC > RST_LOW_CYC)
                       ? ((HALF_CYC > PWR_WAIT_CYC) ? HALF_CYC : PWR_WAIT_CYC)
                       : ((RST_LOW_CYC > PWR_WAIT_CYC) ? RST_LOW_CYC : PWR_WAIT_CYC);
   localparam int TW   = $clog2(TMAX + 1);
   localparam int PW   = $clog2(MAX_PULSES + 1);

   if (HALF_CYC < 4) begin : g_bad_half
      $error("i2c_bus_recover: HALF_CYC must cover the synchronizer delay");
   end
   if (MAX_PULSES < 1) begin : g_bad_pulses
      $error("i2c_bus_recover: MAX_PULSES must be positive");
   end
   if (RST_LOW_CYC < 1 || PWR_WAIT_CYC < 1) begin : g_bad_rst
      $error("i2c_bus_recover: reset timings must be positive");
   end

   logic scl_s, sda_s, stuck, tmr_zero, tmr_en, tmr_load;
   logic [TW-1:0] tmr_val;
   rcv_state_e state_q, state_d;
   logic [PW-1:0] pulse_q, pulse_d;
   logic [RETRY_W-1:0] att_q, att_d, retries_q;
   logic esc_q, done_q, done_d, fail_q, fail_d, att_fail, trig;
   logic scl_oe_q, sda_oe_q, srst_n_q;

   i2c_rcv_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
   );

   i2c_rcv_stuck #(.CYC(STUCK_CYC), .ENABLE(AUTO_DETECT)) u_stuck (
      .clk(clk), .rst_n(rst_n), .arm_i(state_q == RS_IDLE && !fail_q),
      .sda_i(sda_s), .scl_i(scl_s), .stuck_o(stuck)
   );

   i2c_rcv_timer #(.W(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val),
      .en_i(tmr_en), .zero_o(tmr_zero)
   );

   assign trig = start_i || stuck;

   always_comb begin
      state_d  = state_q;
      pulse_d  = pulse_q;
      att_d    = att_q;
      done_d   = done_q;
      fail_d   = fail_q;
      tmr_en   = 1'b1;
      att_fail = 1'b0;
      unique case (state_q)
         RS_IDLE: if (trig) begin
            state_d = RS_PROBE;
            pulse_d = '0;
            att_d   = '0;
            done_d  = 1'b0;
            fail_d  = 1'b0;
         end
         RS_PROBE: if (tmr_zero) state_d = sda_s ? RS_SLO : RS_PLO;
         RS_PLO:   if (tmr_zero) state_d = RS_PHI;
         RS_PHI: begin
            tmr_en = scl_s;
            if (tmr_zero) begin
               if (sda_s)                               state_d  = RS_SLO;
               else if (pulse_q == PW'(MAX_PULSES - 1)) att_fail = 1'b1;
               else begin
                  pulse_d = pulse_q + 1'b1;
                  state_d = RS_PLO;
               end
            end
         end
         RS_SLO:  if (tmr_zero) state_d = RS_SSDA;
         RS_SSDA: if (tmr_zero) state_d = RS_SHI;
         RS_SHI: begin
            tmr_en = scl_s;
            if (tmr_zero) state_d = RS_SREL;
         end
         RS_SREL: if (tmr_zero) begin
            if (sda_s) begin
               state_d = RS_IDLE;
               done_d  = 1'b1;
            end else begin
               att_fail = 1'b1;
            end
         end
         RS_RLOW:  if (tmr_zero) state_d = RS_RWAIT;
         RS_RWAIT: if (tmr_zero) begin
            state_d = RS_IDLE;
            done_d  = 1'b1;
         end
         default: state_d = RS_IDLE;
      endcase
      if (att_fail) begin
         if (att_q != retries_q) begin
            att_d   = att_q + 1'b1;
            pulse_d = '0;
            state_d = RS_PROBE;
         end else if (esc_q) begin
            state_d = RS_RLOW;
         end else begin
            state_d = RS_IDLE;
            fail_d  = 1'b1;
         end
      end
   end

   assign tmr_load = (state_d != state_q);
   always_comb begin
      unique case (state_d)
         RS_RLOW:  tmr_val = TW'(RST_LOW_CYC);
         RS_RWAIT: tmr_val = TW'(PWR_WAIT_CYC);
         default:  tmr_val = TW'(HALF_CYC);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RS_IDLE;
         pulse_q   <= '0;
         att_q     <= '0;
         retries_q <= '0;
         esc_q     <= 1'b0;
         done_q    <= 1'b0;
         fail_q    <= 1'b0;
         scl_oe_q  <= 1'b0;
         sda_oe_q  <= 1'b0;
         srst_n_q  <= 1'b1;
      end else begin
         state_q  <= state_d;
         pulse_q  <= pulse_d;
         att_q    <= att_d;
         done_q   <= done_d;
         fail_q   <= fail_d;
         if (state_q == RS_IDLE && trig) begin
            retries_q <= retries_i;
            esc_q     <= esc_en_i;
         end
         scl_oe_q <= (state_d == RS_PLO) || (state_d == RS_SLO) || (state_d == RS_SSDA);
         sda_oe_q <= (state_d == RS_SSDA) || (state_d == RS_SHI);
         srst_n_q <= (state_d != RS_RLOW);
      end
   end

   assign scl_oe_o      = scl_oe_q;
   assign sda_oe_o      = sda_oe_q;
   assign slave_rst_n_o = srst_n_q;
   assign busy_o        = (state_q != RS_IDLE);
   assign done_o        = done_q;
   assign fail_o        = fail_q;
endmodule

// File: rtl/i2c_rcv_chk.sv
module i2c_rcv_chk #(
   parameter int RST_LOW_CYC = 3000,
   parameter int RETRY_W     = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic [RETRY_W-1:0] retries_i,
   input logic               esc_en_i,
   input logic               scl_i,
   input logic               sda_i,
   input logic               scl_oe_o,
   input logic               sda_oe_o,
   input logic               slave_rst_n_o,
   input logic               busy_o,
   input logic               done_o,
   input logic               fail_o
);
   int unsigned low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              low_cnt <= 0;
      else if (!slave_rst_n_o) low_cnt <= low_cnt + 1;
      else                     low_cnt <= 0;
   end

   // R11
   sda_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> scl_oe_o);

   // R11
   sda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe_o) |-> scl_i);

   // R7
   status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fail_o));

   // R7
   status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (!done_o && !fail_o));

   // R5
   rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slave_rst_n_o) |-> (low_cnt >= RST_LOW_CYC));

   // R5
   rst_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_rst_n_o |-> (busy_o && !scl_oe_o && !sda_oe_o));
endmodule

bind i2c_bus_recover i2c_rcv_chk #(.RST_LOW_CYC(RST_LOW_CYC), .RETRY_W(RETRY_W)) u_chk (.*);

// File: tb/tb_i2c_bus_recover.sv
`timescale 1ns/1ps
module tb_i2c_bus_recover;
   localparam int HALF = 4, RLOW = 20, PWAIT = 10, STUCK = 16, MAXP = 9;

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, esc_en_i = 1'b0;
   logic [1:0] retries_i = 2'd0;
   logic scl_oe_o, sda_oe_o, slave_rst_n_o, busy_o, done_o, fail_o;
   logic scl_line, sda_line;

   int checks = 0, errors = 0;
   logic [63:0] sm_pat = '0;
   int sm_len = 0, sm_idx = 0, stretch_set = 0, st_cnt = 0;
   int edges = 0, stops = 0, rst_pulses = 0, rst_low = 0, min_rst_low = 0;
   int hi_cnt = 0, min_hi = 1000, cyc = 0, rst_rise_cyc = 0;
   bit hi_meas = 0;
   logic p_scl = 1'b1, p_sda = 1'b1, p_srst = 1'b1;

   always #2.5 clk = ~clk;

   function automatic bit sbit(int i);
      return (i >= sm_len) ? 1'b1 : sm_pat[i];
   endfunction

   assign scl_line = !scl_oe_o && (st_cnt == 0);
   assign sda_line = !sda_oe_o && sbit(sm_idx);

   i2c_bus_recover #(.HALF_CYC(HALF), .RST_LOW_CYC(RLOW), .PWR_WAIT_CYC(PWAIT),
                     .STUCK_CYC(STUCK), .MAX_PULSES(MAXP), .RETRY_W(2)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .retries_i(retries_i),
      .esc_en_i(esc_en_i), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .slave_rst_n_o(slave_rst_n_o),
      .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o));

   // target model and line monitor
   always @(negedge clk) begin
      cyc++;
      if (p_scl && !scl_line) begin
         sm_idx++; edges++;
         if (hi_meas && hi_cnt < min_hi) min_hi = hi_cnt;
         hi_meas = 0;
      end else if (!p_scl && scl_line) begin
         hi_cnt = 0; hi_meas = busy_o;
      end else if (scl_line) hi_cnt++;
      if (!p_sda && sda_line && p_scl && scl_line) begin
         stops++; sm_idx = sm_len;
      end
      if (!slave_rst_n_o) begin
         if (p_srst) begin rst_pulses++; rst_low = 0; end
         rst_low++; sm_idx = sm_len;
      end else if (!p_srst) begin
         if (min_rst_low == 0 || rst_low < min_rst_low) min_rst_low = rst_low;
         rst_rise_cyc = cyc;
      end
      if (scl_oe_o) st_cnt = stretch_set;
      else if (st_cnt > 0) st_cnt--;
      p_scl = scl_line; p_sda = sda_line; p_srst = slave_rst_n_o;
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // outcome: 0 freed by STOP, 1 freed by reset strobe, 2 failed
   function automatic void predict(logic [63:0] pat, int len, int retries, bit esc,
                                   output int exp_edges, output int outc);
      int idx = 0;
      bit freed = 0;
      exp_edges = 0;
      outc = esc ? 1 : 2;
      for (int a = 0; a <= retries && !freed; a++) begin
         bit hi = (idx >= len) ? 1'b1 : pat[idx];
         for (int p = 0; p < MAXP && !hi; p++) begin
            idx++; exp_edges++;
            hi = (idx >= len) ? 1'b1 : pat[idx];
         end
         if (hi) begin
            idx++; exp_edges++;
            if (idx >= len || pat[idx]) begin freed = 1; outc = 0; end
         end
      end
   endfunction

   task automatic run_case(string tag, logic [63:0] pat, int len, int retries, bit esc,
                           int stretch, bit use_auto);
      int exp_edges, outc, wait_n;
      predict(pat, len, retries, esc, exp_edges, outc);
      @(negedge clk); #1;
      sm_pat = pat; sm_len = len; sm_idx = 0; stretch_set = stretch;
      retries_i = retries[1:0]; esc_en_i = esc;
      edges = 0; stops = 0; rst_pulses = 0; min_rst_low = 0; min_hi = 1000;
      if (!use_auto) begin
         start_i = 1'b1; @(negedge clk); #1; start_i = 1'b0;
      end
      wait_n = 0;
      while (!busy_o && wait_n < STUCK + 20) begin @(negedge clk); #1; wait_n++; end
      // R8: auto start from a stuck line
      if (use_auto) check("R8 auto start", busy_o, 1);
      if (!use_auto) begin
         repeat (3) @(negedge clk); #1;
         // R12: request during a run is ignored
         start_i = 1'b1; @(negedge clk); #1; start_i = 1'b0;
      end
      while (busy_o) begin @(negedge clk); #1; end
      @(negedge clk); #1;
      $display("case %s: edges %0d outcome %0d", tag, edges, outc);
      // R2 R4 R12: pulse count matches the model
      check({"R2 R4 R12 edges ", tag}, edges, exp_edges);
      // R3 R5 R6: outcome flags
      check({"R3 R5 done ", tag}, done_o, (outc != 2));
      check({"R6 fail ", tag}, fail_o, (outc == 2));
      check({"R5 R6 strobes ", tag}, rst_pulses, (outc == 1));
      if (outc == 0) check({"R3 stop seen ", tag}, (stops > 0), 1);
      if (outc == 1) begin
         check({"R5 strobe width ", tag}, (min_rst_low >= RLOW), 1);
         check({"R5 power wait ", tag}, (cyc - rst_rise_cyc >= PWAIT), 1);
      end
      // R10: SCL high phase never shorter than a half period
      if (min_hi != 1000) check({"R10 high phase ", tag}, (min_hi >= HALF), 1);
      check({"R7 busy low ", tag}, busy_o, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      sm_len = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 scl_oe", scl_oe_o, 0);
      check("R1 sda_oe", sda_oe_o, 0);
      check("R1 strobe", slave_rst_n_o, 1);
      check("R1 busy", busy_o, 0);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      check("R1 done fail", {done_o, fail_o}, 0);

      // clean bus: only the STOP edge
      run_case("clean", 64'h1, 1, 0, 0, 0, 0);
      repeat (10) @(negedge clk); #1;
      // R7: done holds while idle
      check("R7 done held", done_o, 1);
      // three low bits then a one
      run_case("three", 64'b1000, 4, 0, 0, 0, 0);
      // R4: STOP leaves a low bit, second attempt succeeds
      run_case("retry", 64'b1010, 4, 1, 0, 2, 0);
      // R6: same pattern with no retries and no escalation
      run_case("noretry", 64'b1010, 4, 0, 0, 0, 0);
      // R5: stubborn target, escalate
      run_case("escalate", 64'h0, 64, 1, 1, 0, 0);
      // R8: stuck line starts a run on its own
      run_case("auto", 64'b100, 3, 0, 0, 0, 1);
      // R6: stubborn target, no escalation
      run_case("giveup", 64'h0, 64, 2, 0, 3, 0);
      // R9: fail latched, stuck line must not trigger
      sm_pat = 64'h0; sm_len = 64; sm_idx = 0;
      repeat (3 * STUCK) @(negedge clk); #1;
      check("R9 no auto run", busy_o, 0);
      check("R9 fail held", fail_o, 1);

      for (int i = 0; i < 24; i++) begin
         logic [63:0] pat = {$urandom, $urandom};
         int len = $urandom_range(1, 24);
         pat[0] = 1'b0;
         run_case($sformatf("rnd%0d", i), pat, len, $urandom_range(0, 3),
                  1'($urandom_range(0, 1)), $urandom_range(0, 5), 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule